// File: doc/BRIEF.md
# Dual-Clock Pixel Line Buffer with Gated Readout

This block sits between a pixel producer in a 100 MHz domain and a video output stage clocked at 120 MHz. The producer pushes 24-bit RGB words whenever it has them, so its cadence is irregular. The output stage drains one word on each pixel-enable pulse. That pulse arrives every third or fourth output clock, depending on the selected mode. Since every pixel leaves the block in the output domain on a regular enable, the uneven cadence of the source never reaches the pixel edges.

Storage is a dual-clock FIFO. Its read and write pointers cross between the two domains as Gray codes, each through a pair of flops. Full is computed in the write domain and empty in the read domain. A reset sequencer in each domain holds its side idle for a fixed number of clocks after reset is released. Writes are refused until both sides have finished that sequence. On the read side, streaming is re-armed at each raster start and waits until a small backlog has built up. The sync inputs are registered on the same enable as the colour, so they stay aligned with it. The colour is driven black during blanking.

Top module: `pix_line_fifo`

## Requirements
- R1: While `rst_ni` is low, `rgb_o`, `hsync_o`, `vsync_o`, `underflow_o`, `wr_ready_o` and `wr_ack_o` are all 0.
- R2: `wr_ready_o` rises no sooner than 8 write-clock cycles after reset is released, and then stays high. A write offered while it is low is discarded, produces no acknowledge and never appears at the output.
- R3: Each accepted write raises `wr_ack_o` for exactly one write-clock cycle, on the cycle after it is accepted. With the default depth of 16, a write offered to a full buffer is discarded without an acknowledge.
- R4: Accepted pixels leave on `rgb_o` in the order they were written, one pixel per non-blanked `pix_en_i` pulse, with bits [23:16]=red, [15:8]=green and [7:0]=blue carried unchanged.
- R5: After a `line_start_i` pulse, no pixel is consumed until the occupancy exceeds `AE_LVL`, which defaults to 4. Until then, enabled reads output 0 and do not set the underflow flag.
- R6: A `pix_en_i` pulse with `blank_i` high drives `rgb_o` to 0 and consumes no pixel.
- R7: Once streaming is armed, a non-blanked read on an empty buffer drives `rgb_o` to 0 and sets `underflow_o`. The flag stays set until reset.
- R8: On each `pix_en_i` pulse, `hsync_o` and `vsync_o` take the values of `hsync_i` and `vsync_i`, in the same output-clock edge that updates `rgb_o`.
- R9: While `pix_en_i` is low, `rgb_o`, `hsync_o` and `vsync_o` hold their values.
- R10: Draining the buffer to empty at the end of a line needs no recovery. New pixels written afterwards stream correctly on the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock (100 MHz) |
| rclk_i | input | 1 | Read-side clock (120 MHz) |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| wr_en_i | input | 1 | Offer `wr_data_i` for storage |
| wr_data_i | input | 24 | RGB pixel to store |
| wr_ready_o | output | 1 | Reset sequence complete on both sides; writes can be accepted |
| wr_ack_o | output | 1 | One-cycle pulse per stored pixel |
| pix_en_i | input | 1 | Output pixel-enable, read-clock domain |
| line_start_i | input | 1 | Start-of-raster pulse, re-arms read gating |
| blank_i | input | 1 | Blanking interval, forces black |
| hsync_i | input | 1 | Horizontal sync from the timing generator |
| vsync_i | input | 1 | Vertical sync from the timing generator |
| rgb_o | output | 24 | Registered output colour |
| hsync_o | output | 1 | Horizontal sync aligned to `rgb_o` |
| vsync_o | output | 1 | Vertical sync aligned to `rgb_o` |
| underflow_o | output | 1 | Sticky flag: an armed read found the buffer empty |

## Verification
A corrupted pointer or Gray-code synchronizer shows up at the pixel port on the next line as a repeated, skipped or stale colour. The same fault can also show up as a spurious `underflow_o` or a missing write acknowledge at the fill boundary of 16. A wrong arming state shows up on the first enabled read after `line_start_i`: the output is either data where black is expected, or black where data is expected. The sweeps compare each output word with a value computed from its index, so a single misplaced entry is caught on the read where it surfaces.

// File: rtl/plf_pkg.sv
package plf_pkg;
  localparam int unsigned PIX_W = 24;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;
  localparam rgb_t BLACK = '{r: 8'h00, g: 8'h00, b: 8'h00};
endpackage

// File: rtl/plf_sync.sv
module plf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/plf_rst_seq.sv
module plf_rst_seq #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(CYCLES);

  logic [1:0]    rel_q;
  logic [CW-1:0] cnt_q;

  // release synchronizer, then hold for CYCLES clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0;
      cnt_q <= '0;
    end else begin
      rel_q <= {rel_q[0], 1'b1};
      if (rel_q[1] && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end
  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/plf_afifo.sv
module plf_afifo #(
  parameter int unsigned DW     = 24,
  parameter int unsigned AW     = 4,
  parameter int unsigned AE_LVL = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          w_en_i,
  input  logic [DW-1:0] w_data_i,
  output logic          w_acc_o,
  input  logic          r_pop_i,
  output logic [DW-1:0] r_data_o,
  output logic          r_empty_o,
  output logic          r_ae_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] AE_W  = AE_LVL[AW:0];

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [AW:0] wbin_q, wgray_q, wbin_nx;
  logic [AW:0] rbin_q, rgray_q, rbin_nx;
  logic [AW:0] rgray_s, wgray_s, wbin_s, occ;
  logic        w_full;

  // write domain
  assign w_full  = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign w_acc_o = w_en_i & ~w_full;
  assign wbin_nx = wbin_q + 1'b1;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (w_acc_o) begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (w_acc_o) mem[wbin_q[AW-1:0]] <= w_data_i;
  end

  plf_sync #(.W(AW + 1)) u_rsync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray_q),
    .q_o   (rgray_s)
  );

  // read domain
  plf_sync #(.W(AW + 1)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray_q),
    .q_o   (wgray_s)
  );

  assign wbin_s    = g2b(wgray_s);
  assign occ       = wbin_s - rbin_q;
  assign r_empty_o = (rgray_q == wgray_s);
  assign r_ae_o    = (occ <= AE_W);
  assign r_data_o  = mem[rbin_q[AW-1:0]];
  assign rbin_nx   = rbin_q + 1'b1;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (r_pop_i && !r_empty_o) begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
    end
  end
endmodule

// File: rtl/plf_rd_ctrl.sv
module plf_rd_ctrl
  import plf_pkg::*;
(
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic       line_start_i,
  input  logic       pix_en_i,
  input  logic       blank_i,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       empty_i,
  input  logic       ae_i,
  input  rgb_t       data_i,
  output logic       pop_o,
  output rgb_t       rgb_o,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       underflow_o
);
  logic armed_q, want;

  assign want  = pix_en_i & ~blank_i & armed_q & ready_i;
  assign pop_o = want & ~empty_i;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      rgb_o       <= BLACK;
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      if (line_start_i)                  armed_q <= 1'b0;
      else if (ready_i && !armed_q && !ae_i) armed_q <= 1'b1;
      if (pix_en_i) begin
        hsync_o <= hsync_i;
        vsync_o <= vsync_i;
        rgb_o   <= pop_o ? data_i : BLACK;
      end
      if (want && empty_i) underflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pix_line_fifo.sv
module pix_line_fifo
  import plf_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned AE_LVL     = 4,
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  output logic              wr_ready_o,
  output logic              wr_ack_o,
  input  logic              pix_en_i,
  input  logic              line_start_i,
  input  logic              blank_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic [PIX_W-1:0]  rgb_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              underflow_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic w_done, r_done, w_done_r, r_done_w, rd_ready;
  logic w_acc, pop, empty, ae;
  logic [PIX_W-1:0] rdata;
  rgb_t rgb_q;

  plf_rst_seq #(.CYCLES(RST_CYCLES)) u_wseq (.clk_i(wclk_i), .rst_ni(rst_ni), .done_o(w_done));
  plf_rst_seq #(.CYCLES(RST_CYCLES)) u_rseq (.clk_i(rclk_i), .rst_ni(rst_ni), .done_o(r_done));

  plf_sync #(.W(1)) u_rdone (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(r_done), .q_o(r_done_w));
  plf_sync #(.W(1)) u_wdone (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(w_done), .q_o(w_done_r));

  assign wr_ready_o = w_done & r_done_w;
  assign rd_ready   = r_done & w_done_r;

  plf_afifo #(.DW(PIX_W), .AW(AW), .AE_LVL(AE_LVL)) u_fifo (
    .wclk_i   (wclk_i),
    .rclk_i   (rclk_i),
    .rst_ni   (rst_ni),
    .w_en_i   (wr_en_i & wr_ready_o),
    .w_data_i (wr_data_i),
    .w_acc_o  (w_acc),
    .r_pop_i  (pop),
    .r_data_o (rdata),
    .r_empty_o(empty),
    .r_ae_o   (ae)
  );

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ack_o <= 1'b0;
    else         wr_ack_o <= w_acc;
  end

  plf_rd_ctrl u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .ready_i     (rd_ready),
    .line_start_i(line_start_i),
    .pix_en_i    (pix_en_i),
    .blank_i     (blank_i),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .empty_i     (empty),
    .ae_i        (ae),
    .data_i      (rgb_t'(rdata)),
    .pop_o       (pop),
    .rgb_o       (rgb_q),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .underflow_o (underflow_o)
  );

  assign rgb_o = rgb_q;
endmodule

// File: rtl/plf_chk.sv
module plf_chk (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wr_ready_o,
  input logic        wr_ack_o,
  input logic        pix_en_i,
  input logic        blank_i,
  input logic        hsync_i,
  input logic        vsync_i,
  input logic [23:0] rgb_o,
  input logic        hsync_o,
  input logic        vsync_o,
  input logic        underflow_o
);
  // R2
  ready_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_ready_o |=> wr_ready_o);
  // R3
  ack_after_ready_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_ack_o |-> $past(wr_ready_o));
  // R6
  blank_black_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (pix_en_i && blank_i) |=> (rgb_o == 24'h0));
  // R7
  underflow_sticky_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  // R8
  sync_align_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    pix_en_i |=> (hsync_o == $past(hsync_i)) && (vsync_o == $past(vsync_i)));
  // R9
  idle_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(rgb_o) && $stable(hsync_o) && $stable(vsync_o));
endmodule

bind pix_line_fifo plf_chk u_chk (.*);

// File: tb/sim_pix_line_fifo.sv
module sim_pix_line_fifo;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 8;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, pix_en = 0, line_start = 0, blank = 0, hs = 0, vs = 0;
  logic [23:0] wr_data = '0;
  logic wr_ready, wr_ack, hsync_o, vsync_o, underflow;
  logic [23:0] rgb;

  int checks = 0, errors = 0, acks = 0;
  bit finished = 0;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  pix_line_fifo u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_ready_o(wr_ready), .wr_ack_o(wr_ack),
    .pix_en_i(pix_en), .line_start_i(line_start), .blank_i(blank),
    .hsync_i(hs), .vsync_i(vs),
    .rgb_o(rgb), .hsync_o(hsync_o), .vsync_o(vsync_o), .underflow_o(underflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int base, input int i);
    return 24'(base + i * 24'h010203);
  endfunction

  task automatic wr(input logic [23:0] d);
    @(negedge wclk); wr_en = 1; wr_data = d;
    @(negedge wclk); wr_en = 0;
    if (wr_ack) acks++;
  endtask

  task automatic rd(input logic b, input logic h, output logic [23:0] got);
    @(negedge rclk); pix_en = 1; blank = b; hs = h; vs = ~h;
    @(negedge rclk); pix_en = 0; blank = 0;
    got = rgb;
    check("R8 hsync", {31'd0, hsync_o}, {31'd0, h});
    check("R8 vsync", {31'd0, vsync_o}, {31'd0, ~h});
  endtask

  task automatic new_line();
    repeat (12) @(negedge rclk);
    @(negedge rclk); line_start = 1;
    @(negedge rclk); line_start = 0;
    repeat (3) @(negedge rclk);
  endtask

  initial begin
    logic [23:0] got;
    int cyc;
    repeat (4) @(negedge wclk);
    // R1 reset state
    check("R1 rgb", {8'd0, rgb}, 32'd0);
    check("R1 ready", {31'd0, wr_ready}, 32'd0);
    check("R1 ack", {31'd0, wr_ack}, 32'd0);
    check("R1 underflow", {31'd0, underflow}, 32'd0);
    check("R1 sync", {30'd0, hsync_o, vsync_o}, 32'd0);
    rst_n = 1;
    // R2: offer writes while not ready
    cyc = 0;
    wr_en = 1; wr_data = 24'hDEAD01;
    while (!wr_ready && cyc < 200) begin
      @(negedge wclk);
      cyc++;
      if (wr_ack) acks++;
    end
    wr_en = 0;
    check("R2 ready late enough", {31'd0, cyc >= 8}, 32'd1);
    check("R2 no ack before ready", acks, 0);

    // line A: R4, R6, R9, R10 basis
    acks = 0;
    for (int i = 0; i < 10; i++) wr(pat(24'h100000, i));
    @(negedge wclk);
    check("R3 ack count A", acks, 10);
    new_line();
    for (int i = 0; i < 10; i++) begin
      if (i == 3) begin
        rd(1'b1, 1'b0, got);
        check("R6 blank black", {8'd0, got}, 32'd0);
      end
      rd(1'b0, i[0], got);
      check("R4 order A", {8'd0, got}, {8'd0, pat(24'h100000, i)});
      if (i == 5) begin
        repeat (5) @(negedge rclk);
        check("R9 hold", {8'd0, rgb}, {8'd0, pat(24'h100000, 5)});
      end
    end
    check("R7 no underflow after exact drain", {31'd0, underflow}, 32'd0);

    // line B: R5 gating, R10 after drain, R7 underflow
    for (int i = 0; i < 3; i++) wr(pat(24'h200000, i));
    new_line();
    for (int i = 0; i < 3; i++) begin
      rd(1'b0, 1'b1, got);
      check("R5 gated black", {8'd0, got}, 32'd0);
    end
    check("R5 no underflow while gated", {31'd0, underflow}, 32'd0);
    for (int i = 3; i < 5; i++) wr(pat(24'h200000, i));
    repeat (12) @(negedge rclk);
    for (int i = 0; i < 5; i++) begin
      rd(1'b0, 1'b0, got);
      check("R10 R5 stream after backlog", {8'd0, got}, {8'd0, pat(24'h200000, i)});
    end
    check("R7 flag clear before empty read", {31'd0, underflow}, 32'd0);
    rd(1'b0, 1'b0, got);
    check("R7 empty read black", {8'd0, got}, 32'd0);
    check("R7 underflow set", {31'd0, underflow}, 32'd1);
    repeat (6) @(negedge rclk);
    check("R7 underflow sticky", {31'd0, underflow}, 32'd1);

    // line C: R3 full boundary
    acks = 0;
    for (int i = 0; i < 20; i++) wr(pat(24'h300000, i));
    @(negedge wclk);
    check("R3 full drops", acks, 16);
    new_line();
    for (int i = 0; i < 16; i++) begin
      rd(1'b0, 1'b1, got);
      check("R3 R4 order C", {8'd0, got}, {8'd0, pat(24'h300000, i)});
    end
    rd(1'b0, 1'b1, got);
    check("R3 extra writes absent", {8'd0, got}, 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule